// File: doc/BRIEF.md
# Register-Access SPI Slave Port

This block is the serial control path into a bank of byte-wide configuration registers. A host drives an SPI bus in mode 0 (clock idle low, data sampled on the rising edge, changed on the falling edge). The block oversamples the bus with its own system clock. Every transfer opens with a two-byte command. The command holds a read/write flag, a length code and a start address. Data bytes follow, and the address steps by one between them. The bit order is set in a configuration register. It also sets the direction of the address step: most-significant-bit-first counts down and least-significant-bit-first counts up. An unbounded stream always ends at a fixed terminal address.

Writes land in a staging bank. A separate live bank is refreshed from the staging bank only when the host writes an update command to the terminal address. Readback returns either bank, chosen by a select bit. Readback data leaves either on the shared data line, with a drive enable for a 3-wire bus, or on a dedicated output line for a 4-wire bus.

Top module: `rcp_spi_port`

## Requirements
- R1: The 16-bit command word is {bit15 = read(1)/write(0), bits14:13 = length, bits12:0 = start address}. Length 00/01/10 moves 1/2/3 data bytes and 11 streams until the terminal address 0x232.
- R2: In MSB-first order, the command goes high byte first and every byte goes bit 7 first. The address decrements after each data byte.
- R3: In LSB-first order, the whole command goes bit 0 first (low byte, then high byte) and data bytes go bit 0 first. The address increments after each data byte.
- R4: A transfer ends after the byte at 0x232. Counting up runs 0x230, 0x231, 0x232. Counting down runs 0x001, 0x000, 0x232. No address is skipped, and nothing is driven after the end until chip select deasserts.
- R5: Register 0x000 resets to 0x18. Bits 0 and 7 select the 4-wire output, and bits 1 and 6 select LSB-first. Bits 4 and 3 read 1 and bits 5 and 2 read 0. A write is accepted only when bits 7:4 mirror bits 0:3.
- R6: A bit-order change written to 0x000 applies from the very next byte of the same transfer, with no update command.
- R7: Writes to addresses 0x001–0x231 reach only the staging bank. Writing a byte with bit 0 = 1 to 0x232 copies the whole staging bank into the live bank, including the value written one byte earlier.
- R8: The update bit at 0x232 clears itself after one cycle, and 0x232 always reads 0x00.
- R9: Staging-bank register 0x004 bit 0 selects the readback bank: 0 returns staging and 1 returns live. 0x000 and 0x232 read the same under either setting.
- R10: In 3-wire mode, readback is driven on sdio_out, and sdio_oe is high only during the data phase of a read while chip select is low; sdo stays 0. In 4-wire mode, readback is on sdo and sdio_oe stays 0.
- R11: Readback data changes only after a falling SCLK edge and holds steady through the following rising edge.
- R12: Chip select rising in the middle of a byte aborts the transfer. The partial byte is discarded, and the next transfer starts with a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI bus |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_csn | input | 1 | SPI chip select, active low |
| sdio_in | input | 1 | Serial data into the block (shared line input) |
| sdio_out | output | 1 | Readback data for the shared line (3-wire mode) |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo | output | 1 | Readback data on the dedicated line (4-wire mode) |

## Verification
The case of most interest is the byte that rewrites the bit order. That byte's completion changes the order register in the same cycle that the address counter steps, and the next byte must already be decoded in the new order. The bench provokes this with a descending stream starting at 0x001. The stream writes an LSB-first setting into 0x000, then sends an update command to 0x232 bit 0 first. The result is judged by reading the live bank afterwards: the value appears there only if that last byte was taken in the new order. A second pairing is the update copy arriving one byte after the final staging write of an ascending stream. The bench judges it by reading the live copy of that just-written register.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  typedef enum logic [1:0] {
    ST_INS0 = 2'd0,
    ST_INS1 = 2'd1,
    ST_DATA = 2'd2,
    ST_END  = 2'd3
  } rcp_state_e;

  // upper nibble must be the bit-reverse of the lower nibble
  function automatic logic cfg_mirror_ok(input logic [7:0] v);
    return v[7:4] == {v[0], v[1], v[2], v[3]};
  endfunction

endpackage

// File: rtl/rcp_frontend.sv
module rcp_frontend #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sclk,
  input  logic          spi_csn,
  input  logic          sdi,
  input  logic          lsb_first,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_en,
  output logic          cs_act,
  output logic          byte_vld,
  output logic [DW-1:0] byte_val,
  output logic          fall,
  output logic          dout,
  output logic [$clog2(DW)-1:0] bit_cnt
);
  localparam int BCW = $clog2(DW);

  logic          sclk_s, sclk_d, csn_s, din_s;
  logic          rise;
  logic [DW-1:0] sh_q, sh_nxt, tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= 1'b0;
      sclk_d <= 1'b0;
      csn_s  <= 1'b1;
      din_s  <= 1'b0;
    end else begin
      sclk_s <= spi_sclk;
      sclk_d <= sclk_s;
      csn_s  <= spi_csn;
      din_s  <= sdi;
    end
  end

  assign cs_act = ~csn_s;
  assign rise   = sclk_s & ~sclk_d & ~csn_s;
  assign fall   = ~sclk_s & sclk_d & ~csn_s;
  assign sh_nxt = lsb_first ? {din_s, sh_q[DW-1:1]} : {sh_q[DW-2:0], din_s};

  always_ff @(posedge clk) begin
    if (rst || csn_s) begin
      bit_cnt  <= '0;
      sh_q     <= '0;
      byte_vld <= 1'b0;
      byte_val <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (rise) begin
        sh_q    <= sh_nxt;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BCW'(DW - 1)) begin
          byte_vld <= 1'b1;
          byte_val <= sh_nxt;
          bit_cnt  <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      dout <= 1'b0;
    end else if (tx_load) begin
      tx_q <= tx_data;
    end else if (fall && tx_en) begin
      dout <= lsb_first ? tx_q[0] : tx_q[DW-1];
      tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
    end
  end

endmodule

// File: rtl/rcp_ctrl.sv
module rcp_ctrl
  import rcp_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          AW       = 13,
  parameter logic [12:0] TOP_ADDR = 13'h232
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_val,
  input  logic          lsb_first,
  output rcp_state_e    st,
  output logic [AW-1:0] addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_act,
  output logic          tx_load
);
  localparam int IW = 2 * DW;

  logic [DW-1:0] first_q;
  logic [IW-1:0] ins;
  logic          rnw_q;
  logic [1:0]    len_q, left_q;
  logic [AW-1:0] addr_step;
  logic          last;

  assign ins       = lsb_first ? {byte_val, first_q} : {first_q, byte_val};
  assign addr_step = lsb_first ? addr + 1'b1
                   : ((addr == '0) ? AW'(TOP_ADDR) : addr - 1'b1);
  assign last      = (addr == AW'(TOP_ADDR)) || (len_q != 2'b11 && left_q == 2'd0);
  assign rd_act    = (st == ST_DATA) && rnw_q;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      st      <= ST_INS0;
      first_q <= '0;
      rnw_q   <= 1'b0;
      len_q   <= '0;
      left_q  <= '0;
      addr    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      tx_load <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      tx_load <= 1'b0;
      if (byte_vld) begin
        case (st)
          ST_INS0: begin
            first_q <= byte_val;
            st      <= ST_INS1;
          end
          ST_INS1: begin
            rnw_q   <= ins[IW-1];
            len_q   <= ins[IW-2:IW-3];
            left_q  <= ins[IW-2:IW-3];
            addr    <= ins[AW-1:0];
            tx_load <= ins[IW-1];
            st      <= ST_DATA;
          end
          ST_DATA: begin
            wr_en   <= !rnw_q;
            wr_addr <= addr;
            wr_data <= byte_val;
            if (last) begin
              st <= ST_END;
            end else begin
              addr    <= addr_step;
              left_q  <= left_q - 1'b1;
              tx_load <= rnw_q;
            end
          end
          default: st <= ST_END;
        endcase
      end
    end
  end

endmodule

// File: rtl/rcp_regbank.sv
module rcp_regbank
  import rcp_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          AW        = 13,
  parameter logic [12:0] TOP_ADDR  = 13'h232,
  parameter int          SEL_ADDR  = 4,
  parameter logic [7:0]  CFG_RESET = 8'h18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    cfg,
  output logic          upd
);
  localparam int DEPTH = int'(TOP_ADDR) + 1;
  localparam int IXW   = $clog2(DEPTH);

  logic [DW-1:0] stage_q [DEPTH];
  logic [DW-1:0] live_q  [DEPTH];
  logic          sel_live;

  assign sel_live = stage_q[SEL_ADDR][0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
      upd <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      upd <= 1'b0;
      if (wr_en) begin
        if (wr_addr == '0) begin
          if (cfg_mirror_ok(wr_data[7:0]))
            cfg <= {wr_data[7:6], 4'b0110, wr_data[1:0]};
        end else if (wr_addr == AW'(TOP_ADDR)) begin
          upd <= wr_data[0];
        end else if (wr_addr < AW'(TOP_ADDR)) begin
          stage_q[wr_addr[IXW-1:0]] <= wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) live_q[i] <= '0;
    end else if (upd) begin
      for (int i = 0; i < DEPTH; i++) live_q[i] <= stage_q[i];
    end
  end

  always_comb begin
    if (rd_addr == '0)
      rd_data = DW'(cfg);
    else if (rd_addr >= AW'(TOP_ADDR))
      rd_data = '0;
    else if (sel_live)
      rd_data = live_q[rd_addr[IXW-1:0]];
    else
      rd_data = stage_q[rd_addr[IXW-1:0]];
  end

endmodule

// File: rtl/rcp_spi_port.sv
module rcp_spi_port
  import rcp_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          AW        = 13,
  parameter logic [12:0] TOP_ADDR  = 13'h232,
  parameter int          SEL_ADDR  = 4,
  parameter logic [7:0]  CFG_RESET = 8'h18
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_csn,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo
);
  localparam int BCW = $clog2(DW);

  logic          cs_act, byte_vld, fall, dout, upd;
  logic [DW-1:0] byte_val, wr_data, rd_data;
  logic [BCW-1:0] bit_cnt;
  logic [AW-1:0] addr, wr_addr;
  logic          wr_en, rd_act, tx_load;
  logic [7:0]    cfg;
  rcp_state_e    st;
  logic          uni, lsb;

  assign uni = cfg[0];
  assign lsb = cfg[1];

  rcp_frontend #(.DW(DW)) fe_i (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .sdi(sdio_in), .lsb_first(lsb), .tx_load(tx_load), .tx_data(rd_data),
    .tx_en(rd_act), .cs_act(cs_act), .byte_vld(byte_vld),
    .byte_val(byte_val), .fall(fall), .dout(dout), .bit_cnt(bit_cnt)
  );

  rcp_ctrl #(.DW(DW), .AW(AW), .TOP_ADDR(TOP_ADDR)) ctrl_i (
    .clk(clk), .rst(rst), .cs_act(cs_act), .byte_vld(byte_vld),
    .byte_val(byte_val), .lsb_first(lsb), .st(st), .addr(addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_act(rd_act), .tx_load(tx_load)
  );

  rcp_regbank #(
    .DW(DW), .AW(AW), .TOP_ADDR(TOP_ADDR), .SEL_ADDR(SEL_ADDR),
    .CFG_RESET(CFG_RESET)
  ) bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data),
    .cfg(cfg), .upd(upd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdio_out <= 1'b0;
      sdio_oe  <= 1'b0;
      sdo      <= 1'b0;
    end else begin
      sdio_out <= uni ? 1'b0 : dout;
      sdo      <= uni ? dout : 1'b0;
      sdio_oe  <= rd_act & cs_act & ~uni;
    end
  end

endmodule

// File: rtl/rcp_spi_port_chk.sv
module rcp_spi_port_chk
  import rcp_pkg::*;
#(
  parameter int BCW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           fall,
  input logic           dout,
  input logic           upd,
  input logic [7:0]     cfg,
  input logic           sdio_oe,
  input logic           cs_act,
  input rcp_state_e     st,
  input logic [BCW-1:0] bit_cnt
);
  // R11
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(dout));

  // R8
  upd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> !upd);

  // R5
  cfg_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    cfg[7:4] == {cfg[0], cfg[1], cfg[2], cfg[3]});

  // R10
  uni_no_oe_chk: assert property (@(posedge clk) disable iff (rst)
    cfg[0] |=> !sdio_oe);

  // R10
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !sdio_oe);

  // R12
  abort_clears_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> bit_cnt == '0);

  // R4
  end_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_END && cs_act) |=> st == ST_END);

endmodule

bind rcp_spi_port rcp_spi_port_chk #(.BCW(BCW)) chk_i (
  .clk(clk), .rst(rst), .fall(fall), .dout(dout), .upd(upd), .cfg(cfg),
  .sdio_oe(sdio_oe), .cs_act(cs_act), .st(st), .bit_cnt(bit_cnt)
);

// File: tb/rcp_spi_port_tb_top.sv
module rcp_spi_port_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_csn = 1'b1;
  logic sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo;

  int checks = 0;
  int errors = 0;
  logic lsb_mode = 1'b0;
  logic uni_mode = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  rcp_spi_port dut_i (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo)
  );

  // {address[20:8], data[7:0]}
  localparam logic [20:0] VEC [6] = '{
    {13'h010, 8'hA5}, {13'h001, 8'h3C}, {13'h231, 8'h81},
    {13'h100, 8'hFF}, {13'h0FF, 8'h00}, {13'h022, 8'h5A}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic xfer_bit(input logic din, output logic dq);
    sdio_in = din;
    repeat (6) @(negedge clk);
    dq = uni_mode ? sdo : sdio_out;
    spi_sclk = 1'b1;
    repeat (6) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic xfer_byte(input logic [7:0] b, output logic [7:0] r);
    logic q;
    for (int i = 0; i < 8; i++) begin
      int k = lsb_mode ? i : 7 - i;
      xfer_bit(b[k], q);
      r[k] = q;
    end
  endtask

  task automatic begin_x(input logic rnw, input logic [1:0] len, input logic [12:0] a);
    logic [15:0] w;
    logic [7:0] junk;
    w = {rnw, len, a};
    spi_csn = 1'b0;
    repeat (6) @(negedge clk);
    if (lsb_mode) begin
      xfer_byte(w[7:0], junk);
      xfer_byte(w[15:8], junk);
    end else begin
      xfer_byte(w[15:8], junk);
      xfer_byte(w[7:0], junk);
    end
  endtask

  task automatic end_x();
    repeat (6) @(negedge clk);
    spi_csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] junk;
    begin_x(1'b0, 2'b00, a);
    xfer_byte(d, junk);
    end_x();
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] d);
    begin_x(1'b1, 2'b00, a);
    xfer_byte(8'h00, d);
    end_x();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, junk;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // reset state: outputs idle, config register default (R5, R10)
    check("R10 reset oe", {7'd0, sdio_oe}, 8'h00);
    check("R10 reset sdo", {7'd0, sdo}, 8'h00);
    rd1(13'h000, r);
    check("R5 cfg reset value", r, 8'h18);

    // table: single-byte write then read, MSB-first (R1, R2)
    foreach (VEC[i]) begin
      wr1(VEC[i][20:8], VEC[i][7:0]);
      rd1(VEC[i][20:8], r);
      check("R1 R2 single byte write/read", r, VEC[i][7:0]);
    end

    // 3-byte write, address counts down (R1, R2)
    begin_x(1'b0, 2'b10, 13'h052);
    xfer_byte(8'h11, junk);
    xfer_byte(8'h22, junk);
    xfer_byte(8'h33, junk);
    end_x();
    rd1(13'h051, r); check("R2 descending second byte", r, 8'h22);
    rd1(13'h050, r); check("R2 descending third byte", r, 8'h33);
    // 2-byte read of the same area, oe high in data phase (R1, R10)
    begin_x(1'b1, 2'b01, 13'h052);
    repeat (6) @(negedge clk);
    check("R10 oe during read data", {7'd0, sdio_oe}, 8'h01);
    xfer_byte(8'h00, r); check("R1 burst read byte 0", r, 8'h11);
    xfer_byte(8'h00, r); check("R1 burst read byte 1", r, 8'h22);
    check("R10 sdo idle in 3-wire", {7'd0, sdo}, 8'h00);
    xfer_byte(8'h00, r);
    repeat (3) @(negedge clk);
    check("R1 length honoured, oe dropped", {7'd0, sdio_oe}, 8'h00);
    end_x();

    // double buffering and bank select (R7, R8, R9)
    wr1(13'h004, 8'h01);
    rd1(13'h052, r); check("R7 live bank untouched before update", r, 8'h00);
    rd1(13'h000, r); check("R9 cfg same under live select", r, 8'h18);
    wr1(13'h232, 8'h01);
    rd1(13'h052, r); check("R7 live bank after update", r, 8'h11);
    rd1(13'h232, r); check("R8 update reads zero", r, 8'h00);
    wr1(13'h052, 8'h77);
    rd1(13'h052, r); check("R7 new stage write hidden", r, 8'h11);
    wr1(13'h004, 8'h00);
    rd1(13'h052, r); check("R9 staging bank readback", r, 8'h77);

    // abort mid-byte (R12)
    begin_x(1'b0, 2'b00, 13'h010);
    for (int i = 0; i < 4; i++) xfer_bit(1'b0, r[0]);
    end_x();
    rd1(13'h010, r); check("R12 partial byte discarded", r, 8'hA5);

    // non-mirrored config write ignored (R5)
    wr1(13'h000, 8'h1A);
    rd1(13'h000, r); check("R5 unmirrored write ignored", r, 8'h18);

    // descending stream 0x001, 0x000 (order flip), 0x232 in new order (R4, R6)
    begin_x(1'b0, 2'b11, 13'h001);
    xfer_byte(8'h44, junk);
    xfer_byte(8'h5A, junk);
    lsb_mode = 1'b1;
    xfer_byte(8'h01, junk);
    end_x();
    rd1(13'h000, r); check("R6 order register took effect", r, 8'h5A);
    rd1(13'h001, r); check("R3 R4 descending stream 0x001", r, 8'h44);
    wr1(13'h004, 8'h01);
    rd1(13'h052, r); check("R6 update byte decoded in new order", r, 8'h77);
    wr1(13'h004, 8'h00);

    // ascending stream 0x230, 0x231, update at 0x232 (R3, R4, R7)
    begin_x(1'b0, 2'b11, 13'h230);
    xfer_byte(8'hC1, junk);
    xfer_byte(8'hC2, junk);
    xfer_byte(8'h01, junk);
    end_x();
    wr1(13'h004, 8'h01);
    rd1(13'h231, r); check("R7 update captures previous byte", r, 8'hC2);
    wr1(13'h004, 8'h00);
    begin_x(1'b1, 2'b11, 13'h230);
    xfer_byte(8'h00, r); check("R3 ascending read 0x230", r, 8'hC1);
    xfer_byte(8'h00, r); check("R3 ascending read 0x231", r, 8'hC2);
    xfer_byte(8'h00, r); check("R4 R8 terminal reads zero", r, 8'h00);
    xfer_byte(8'h00, r);
    check("R4 stream stopped, no drive", {7'd0, sdio_oe}, 8'h00);
    end_x();

    // 4-wire mode: bits 7,6,4,3,1,0 (R10, R11)
    wr1(13'h000, 8'hDB);
    uni_mode = 1'b1;
    begin_x(1'b1, 2'b00, 13'h022);
    repeat (6) @(negedge clk);
    check("R10 no oe in 4-wire", {7'd0, sdio_oe}, 8'h00);
    xfer_byte(8'h00, r);
    check("R10 R11 readback on sdo", r, 8'h5A);
    end_x();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule